// File: doc/BRIEF.md
# Fault-Detecting Composite-Field Byte Substitution Unit

This block substitutes one byte in either direction of the AES cipher. When the direction select is low it applies the forward S-box. When it is high it applies the inverse S-box. There is no lookup table. The multiplicative inverse in GF(2^8) is worked out in a tower field GF((2^4)^2): a linear change of basis takes the byte into the tower field, a closed-form inversion runs there, and a second linear map takes the result back. One datapath serves both directions. In the inverse direction the inverse affine transform runs before the field inversion. In the forward direction the forward affine transform runs after it. The two basis-change matrices are not written out. Package functions search for the tower-field generators at elaboration time and derive both matrices from them.

Each stage has a concurrent check. For every linear stage, the parity of the stage output is predicted from the stage input and compared with the actual parity. For the field inversion, the result is multiplied back against its operand in the tower field and must give one. The error output is the OR of all stage mismatches.

For test, an 8-bit mask can be XORed onto the output of one chosen stage. The parameter `FAULT_SITE` picks the stage. The results are registered once when `OUT_REG` is 1, which is the default.

Top module: `aes_sbox_fd`

## Requirements
- R1: With `inv_i` = 0 and no fault mask, `data_o` equals the AES forward S-box of `byte_i`. For example, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With `inv_i` = 1 and no fault mask, `data_o` equals the AES inverse S-box of `byte_i`. For example, 0x7C gives 0x01.
- R3: Byte 0x00 gives 0x63 in the forward direction. Byte 0x63 gives 0x00 in the inverse direction. The field inverse of zero is taken as zero.
- R4: With `fault_mask_i` = 0, `err_o` is 0 for all 256 inputs in both directions.
- R5: A mask with exactly one bit set, at any of the 8 positions, raises `err_o` for every input in both directions.
- R6: A mask with an odd number of set bits (3, 5 or 7) raises `err_o`.
- R7: While `rst_n` is low, `data_o` and `err_o` are both 0, whatever the inputs are.
- R8: With `OUT_REG` = 1, the `data_o` and `err_o` seen after a rising clock edge belong to the inputs present at that edge. Consecutive bytes in alternating directions each come out on their own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Byte to substitute |
| inv_i | input | 1 | 0 = forward S-box, 1 = inverse S-box |
| fault_mask_i | input | 8 | Test mask XORed onto the stage chosen by `FAULT_SITE` |
| data_o | output | 8 | Substituted byte |
| err_o | output | 1 | High when any stage check disagrees |

## Verification
All logic between the inputs and the output register is combinational. Both `data_o` and `err_o` are therefore due exactly one rising edge after the inputs are applied. The driver changes the inputs on falling edges and pushes the expected pair into a queue at that moment. The monitor pops one entry per rising edge and compares it 2 ns after that edge. Any extra or missing cycle in the design therefore shows up as a mismatch against the wrong queue entry. The reset values are read directly at a falling edge while reset is held.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

   typedef struct packed {
      logic [63:0] to_cmp;   // standard -> tower basis, column k at [8k+:8]
      logic [63:0] to_std;   // tower -> standard basis
      logic [3:0]  lam;      // norm constant of y^2 + y + lam
   } tower_t;

   function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r, x;
      r = '0;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      end
      return r;
   endfunction

   function automatic logic [3:0] gf4_mul(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] r, x;
      r = '0;
      x = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) r = r ^ x;
         x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
      end
      return r;
   endfunction

   // a^14 = a^-1 in GF(16); zero stays zero
   function automatic logic [3:0] gf4_inv(input logic [3:0] a);
      logic [3:0] r;
      r = 4'h1;
      for (int i = 0; i < 14; i++) r = gf4_mul(r, a);
      return r;
   endfunction

   function automatic logic [7:0] lin_map(input logic [63:0] cols, input logic [7:0] v);
      logic [7:0] r;
      r = '0;
      for (int k = 0; k < 8; k++) if (v[k]) r = r ^ cols[8*k +: 8];
      return r;
   endfunction

   // parity of lin_map(cols, v) equals ^(v & par_mask(cols))
   function automatic logic [7:0] par_mask(input logic [63:0] cols);
      logic [7:0] m;
      for (int k = 0; k < 8; k++) m[k] = ^cols[8*k +: 8];
      return m;
   endfunction

   function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
      return (b << n) | (b >> (8 - n));
   endfunction

   function automatic logic [7:0] aff_fwd(input logic [7:0] b);
      return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
   endfunction

   function automatic logic [7:0] aff_inv(input logic [7:0] x);
      return rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05;
   endfunction

   // Search the tower generators and derive both basis-change matrices
   function automatic tower_t build_tower();
      tower_t     t;
      logic [7:0] al, yr, lamx, w;
      logic [7:0] pw [4];
      logic       has_root;
      t = '0;
      al = '0;
      for (int c = 2; c < 256; c++)
         if (al == 8'h00 &&
             (gf8_mul(gf8_mul(gf8_mul(8'(c), 8'(c)), 8'(c)), 8'(c)) ^ 8'(c) ^ 8'h01) == 8'h00)
            al = 8'(c);
      pw[0] = 8'h01;
      for (int i = 1; i < 4; i++) pw[i] = gf8_mul(pw[i-1], al);
      for (int l = 1; l < 16; l++) begin
         has_root = 1'b0;
         for (int s = 0; s < 16; s++)
            if ((gf4_mul(4'(s), 4'(s)) ^ 4'(s)) == 4'(l)) has_root = 1'b1;
         if (t.lam == 4'h0 && !has_root) t.lam = 4'(l);
      end
      lamx = '0;
      for (int i = 0; i < 4; i++) if (t.lam[i]) lamx = lamx ^ pw[i];
      yr = '0;
      for (int c = 2; c < 256; c++)
         if (yr == 8'h00 && (gf8_mul(8'(c), 8'(c)) ^ 8'(c) ^ lamx) == 8'h00) yr = 8'(c);
      for (int i = 0; i < 4; i++) begin
         t.to_std[8*i +: 8]     = pw[i];
         t.to_std[8*(i+4) +: 8] = gf8_mul(pw[i], yr);
      end
      for (int v = 0; v < 256; v++) begin
         w = lin_map(t.to_std, 8'(v));
         for (int k = 0; k < 8; k++) if (w == (8'h01 << k)) t.to_cmp[8*k +: 8] = 8'(v);
      end
      return t;
   endfunction

   localparam tower_t TOWER = build_tower();

   // product in GF(16)[y]/(y^2 + y + lam); high nibble is the y coefficient
   function automatic logic [7:0] cmp_mul(input logic [7:0] a, input logic [7:0] b);
      logic [3:0] hh;
      hh = gf4_mul(a[7:4], b[7:4]);
      return {hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]),
              gf4_mul(hh, TOWER.lam) ^ gf4_mul(a[3:0], b[3:0])};
   endfunction

endpackage

// File: rtl/sbox_lin_stage.sv
module sbox_lin_stage #(
   parameter logic [63:0] COLS = 64'h8040201008040201
) (
   input  logic [7:0] a_i,
   input  logic [7:0] fault_i,
   output logic [7:0] y_o,
   output logic       mis_o
);
   localparam logic [7:0] PMASK = sbox_pkg::par_mask(COLS);

   logic [7:0] raw;
   logic       pred;

   always_comb begin
      raw   = sbox_pkg::lin_map(COLS, a_i);
      y_o   = raw ^ fault_i;
      pred  = ^(a_i & PMASK);
      mis_o = pred ^ (^y_o);
   end
endmodule

// File: rtl/sbox_affine_stage.sv
module sbox_affine_stage #(
   parameter bit         INVERSE = 1'b0,
   parameter logic [7:0] CONST   = INVERSE ? 8'h05 : 8'h63
) (
   input  logic [7:0] a_i,
   input  logic       en_i,
   input  logic [7:0] fault_i,
   output logic [7:0] y_o,
   output logic       mis_o
);
   // both transforms sum an odd number of rotations, so the output
   // parity is the input parity plus the parity of the constant
   localparam logic CPAR = ^CONST;

   logic [7:0] xf;
   logic       pred;

   if (INVERSE) begin : g_inv
      assign xf = sbox_pkg::aff_inv(a_i);
   end else begin : g_fwd
      assign xf = sbox_pkg::aff_fwd(a_i);
   end

   always_comb begin
      y_o   = (en_i ? xf : a_i) ^ fault_i;
      pred  = (^a_i) ^ (en_i & CPAR);
      mis_o = pred ^ (^y_o);
   end
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv (
   input  logic [7:0] a_i,
   input  logic [7:0] fault_i,
   output logic [7:0] y_o,
   output logic       mis_o
);
   localparam logic [3:0] LAM = sbox_pkg::TOWER.lam;

   logic [3:0] ah, al, dlt, dinv;
   logic [7:0] prod;

   always_comb begin
      ah    = a_i[7:4];
      al    = a_i[3:0];
      dlt   = sbox_pkg::gf4_mul(sbox_pkg::gf4_mul(ah, ah), LAM)
            ^ sbox_pkg::gf4_mul(ah, al)
            ^ sbox_pkg::gf4_mul(al, al);
      dinv  = sbox_pkg::gf4_inv(dlt);
      y_o   = {sbox_pkg::gf4_mul(ah, dinv), sbox_pkg::gf4_mul(ah ^ al, dinv)} ^ fault_i;
      // operand times result must be one; zero must map to zero
      prod  = sbox_pkg::cmp_mul(a_i, y_o);
      mis_o = (a_i == 8'h00) ? (y_o != 8'h00) : (prod != 8'h01);
   end
endmodule

// File: rtl/aes_sbox_fd.sv
module aes_sbox_fd #(
   parameter int FAULT_SITE = 1,   // 0 pre-affine, 1 to-tower, 2 inversion, 3 from-tower, 4 post-affine
   parameter bit OUT_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] byte_i,
   input  logic       inv_i,
   input  logic [7:0] fault_mask_i,
   output logic [7:0] data_o,
   output logic       err_o
);
   localparam int NSTAGE = 5;

   if (FAULT_SITE < 0 || FAULT_SITE >= NSTAGE) begin : g_bad_site
      $error("FAULT_SITE out of range");
   end

   logic [7:0]        fm [NSTAGE];
   logic [NSTAGE-1:0] mis;
   logic [7:0]        s_pre, s_cmp, s_inv, s_std, s_out;
   logic              err_c;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_fm
      assign fm[k] = (FAULT_SITE == k) ? fault_mask_i : 8'h00;
   end

   sbox_affine_stage #(.INVERSE(1'b1)) u_pre (
      .a_i(byte_i), .en_i(inv_i), .fault_i(fm[0]), .y_o(s_pre), .mis_o(mis[0]));

   sbox_lin_stage #(.COLS(sbox_pkg::TOWER.to_cmp)) u_to_cmp (
      .a_i(s_pre), .fault_i(fm[1]), .y_o(s_cmp), .mis_o(mis[1]));

   sbox_tower_inv u_inv (
      .a_i(s_cmp), .fault_i(fm[2]), .y_o(s_inv), .mis_o(mis[2]));

   sbox_lin_stage #(.COLS(sbox_pkg::TOWER.to_std)) u_to_std (
      .a_i(s_inv), .fault_i(fm[3]), .y_o(s_std), .mis_o(mis[3]));

   sbox_affine_stage #(.INVERSE(1'b0)) u_post (
      .a_i(s_std), .en_i(!inv_i), .fault_i(fm[4]), .y_o(s_out), .mis_o(mis[4]));

   assign err_c = |mis;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o <= 8'h00;
            err_o  <= 1'b0;
         end else begin
            data_o <= s_out;
            err_o  <= err_c;
         end
      end

      // R3
      zero_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!inv_i && byte_i == 8'h00 && fault_mask_i == 8'h00) |=> data_o == 8'h63);
      // R3
      zero_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_i && byte_i == 8'h63 && fault_mask_i == 8'h00) |=> data_o == 8'h00);
      // R4
      no_false_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_mask_i == 8'h00) |=> !err_o);
      // R5
      single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(fault_mask_i) == 1) |=> err_o);
      // R6
      odd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(fault_mask_i) % 2 == 1) |=> err_o);
      // R8
      mode_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_mask_i == 8'h00 && byte_i == 8'h01 && !inv_i) |=> data_o == 8'h7c);
   end else begin : g_comb
      assign data_o = s_out;
      assign err_o  = err_c;
   end
endmodule

// File: tb/aes_sbox_fd_bench.sv
module aes_sbox_fd_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] byte_i;
   logic       inv_i;
   logic [7:0] fault_mask_i;
   logic [7:0] data_o;
   logic       err_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] fwd_tab [256];
   logic [7:0] inv_tab [256];

   logic [7:0] q_data [$];
   logic       q_err  [$];
   bit         q_chkd [$];
   string      q_tag  [$];

   always #4 clk = ~clk;

   aes_sbox_fd u_aes_sbox_fd (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .inv_i(inv_i),
      .fault_mask_i(fault_mask_i), .data_o(data_o), .err_o(err_o));

   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   task automatic build_ref();
      logic [7:0] x, b, s;
      for (int v = 0; v < 256; v++) begin
         x = 8'h01;
         for (int e = 0; e < 254; e++) x = ref_mul(x, 8'(v));
         b = (v == 0) ? 8'h00 : x;
         for (int i = 0; i < 8; i++)
            s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
         fwd_tab[v] = s;
      end
      for (int v = 0; v < 256; v++) inv_tab[fwd_tab[v]] = 8'(v);
   endtask

   task automatic send(input logic [7:0] b, input logic inv, input logic [7:0] m,
                       input logic [7:0] exp_d, input logic exp_e, input bit chk_d,
                       input string tag);
      @(negedge clk);
      byte_i       = b;
      inv_i        = inv;
      fault_mask_i = m;
      q_data.push_back(exp_d);
      q_err.push_back(exp_e);
      q_chkd.push_back(chk_d);
      q_tag.push_back(tag);
   endtask

   // monitor: one result per rising edge, read 2 ns after it
   always @(posedge clk) begin
      if (rst_n === 1'b1) begin
         #2;
         if (q_data.size() > 0) begin
            logic [7:0] ed;
            logic       ee;
            bit         cd;
            string      tg;
            ed = q_data.pop_front();
            ee = q_err.pop_front();
            cd = q_chkd.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if ((cd && data_o !== ed) || err_o !== ee) begin
               failures++;
               $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                        tg, data_o, err_o, cd ? ed : data_o, ee);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL R8: watchdog expired, actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      byte_i = 8'h55;
      inv_i = 1'b0;
      fault_mask_i = 8'h00;
      build_ref();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: outputs cleared under reset despite active inputs
      checks++;
      if (data_o !== 8'h00 || err_o !== 1'b0) begin
         failures++;
         $display("FAIL R7: actual data=%h err=%b expected data=00 err=0", data_o, err_o);
      end
      rst_n = 1'b1;

      // R3 corner values
      send(8'h00, 1'b0, 8'h00, 8'h63, 1'b0, 1'b1, "R3");
      send(8'h63, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, "R3");
      // R1 known points
      send(8'h01, 1'b0, 8'h00, 8'h7c, 1'b0, 1'b1, "R1");
      send(8'h53, 1'b0, 8'h00, 8'hed, 1'b0, 1'b1, "R1");
      // R2 known point
      send(8'h7c, 1'b1, 8'h00, 8'h01, 1'b0, 1'b1, "R2");
      // R8: back-to-back alternating directions
      for (int i = 0; i < 16; i++) begin
         if (i % 2 == 0) send(8'(i * 17), 1'b0, 8'h00, fwd_tab[i * 17], 1'b0, 1'b1, "R8");
         else            send(8'(i * 17), 1'b1, 8'h00, inv_tab[i * 17], 1'b0, 1'b1, "R8");
      end
      // R1 / R4: full forward sweep
      for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 8'h00, fwd_tab[v], 1'b0, 1'b1, "R1/R4");
      // R2 / R4: full inverse sweep
      for (int v = 0; v < 256; v++) send(8'(v), 1'b1, 8'h00, inv_tab[v], 1'b0, 1'b1, "R2/R4");
      // R5: every single-bit mask, every input, both directions
      for (int d = 0; d < 2; d++)
         for (int k = 0; k < 8; k++)
            for (int v = 0; v < 256; v++)
               send(8'(v), d[0], 8'h01 << k, 8'h00, 1'b1, 1'b0, "R5");
      // R6: odd-weight multi-bit masks
      for (int v = 0; v < 256; v += 5) begin
         send(8'(v), 1'b0, 8'h07, 8'h00, 1'b1, 1'b0, "R6");
         send(8'(v), 1'b1, 8'h1f, 8'h00, 1'b1, 1'b0, "R6");
         send(8'(v), 1'b0, 8'hfe, 8'h00, 1'b1, 1'b0, "R6");
      end
      // clean item after faults: no lingering alarm (R4)
      send(8'h53, 1'b0, 8'h00, 8'hed, 1'b0, 1'b1, "R4");
      @(negedge clk);
      fault_mask_i = 8'h00;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule